// File: doc/BRIEF.md
# SPI Chip-Select Line Controller

This block owns the chip-select pins of an SPI master. It drives a parameterised set of select lines (four by default) and decides, every clock, which of them is active and at what level. A binary index chooses the target line. Two modes exist.

- **Automatic mode:** the transfer engine's burst-busy flag frames the select pulse.
- **Manual mode:** software places the target line at any level it chooses through a level bit.

A polarity input states whether selects are active low or active high. The same input also fixes the resting level of every line that is not the target, in both modes.

In automatic mode the index is frozen for the length of a burst. A target change written while a burst is running therefore cannot move the select to another device mid-transfer. Every output comes straight from a flop, so the pins are glitch-free. The engine starts its serial clock one cycle after raising burst-busy, which gives the select a full cycle of setup.

Top module: `spi_csel_ctrl`

## Requirements
- R1: The block has four select outputs `cs_o[3:0]` and a 2-bit index `sel_idx`; index value k names line `cs_o[k]`. At most one line differs from the resting level at any time.
- R2: Every output is registered. A change on any input shows at `cs_o` exactly one clock edge after that edge samples it.
- R3: When `manual_en` is 1, the line named by `sel_idx` is driven to the value of `manual_lvl`, whatever the polarity and burst state.
- R4: When `act_low` is 1, every line that is not driven active rests high. When `act_low` is 0, every such line rests low; the active level is then 1.
- R5: When `manual_en` is 0, an edge that samples `burst_busy` high drives the locked target line to its active level, which is the inverse of `act_low`.
- R6: When `manual_en` is 0, an edge that samples `burst_busy` low drives all four lines to the resting level.
- R7: In automatic mode the target is locked at the first edge that samples `burst_busy` high. Index changes made while the burst is still sampled high are ignored until an edge samples `burst_busy` low.
- R8: While `rst_n` is low, all four lines are high, which is the resting level for the default active-low polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_idx | input | 2 | Target line index |
| manual_en | input | 1 | 1 = manual mode, 0 = automatic mode |
| manual_lvl | input | 1 | Level of the target line in manual mode |
| act_low | input | 1 | 1 = selects are active low |
| burst_busy | input | 1 | High while the transfer engine runs a burst |
| cs_o | output | 4 | Chip-select lines |

## Verification
Each result on `cs_o` is due one edge after the inputs that cause it are sampled. The one exception is the locked index, which is due one edge after the burst is first seen and holds until the edge after the burst is seen to end. The bench drives inputs on the falling edge and updates its own model at the rising edge from the same input values the design samples. It compares all four lines at the next falling edge, every cycle, with nothing skipped. Scenarios cover reset, idle and bursting in automatic mode on every index, a mid-burst retarget, manual levels under both polarities, and a long pseudo-random run.

// File: rtl/spi_csel_pkg.sv
package spi_csel_pkg;

  // Level a line rests at when it is not driven active.
  function automatic logic rest_level(input logic act_low);
    return act_low;
  endfunction

  // Next level of one line, given whether it is the current target.
  function automatic logic line_next(input logic is_target,
                                     input logic manual,
                                     input logic lvl,
                                     input logic busy,
                                     input logic act_low);
    logic lv;
    if (!is_target)  lv = rest_level(act_low);
    else if (manual) lv = lvl;
    else if (busy)   lv = ~rest_level(act_low);
    else             lv = rest_level(act_low);
    return lv;
  endfunction

endpackage

// File: rtl/csel_index_lock.sv
module csel_index_lock #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] sel_idx,
  input  logic             burst_busy,
  output logic [IDX_W-1:0] eff_idx,
  output logic [IDX_W-1:0] lock_idx,
  output logic             burst_q,
  output logic             burst_start
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q  <= 1'b0;
      lock_idx <= '0;
    end else begin
      burst_q <= burst_busy;
      if (!burst_q) lock_idx <= sel_idx;
    end
  end

  // While a burst is known to run, the frozen index wins.
  assign eff_idx     = burst_q ? lock_idx : sel_idx;
  assign burst_start = burst_busy && !burst_q;

endmodule

// File: rtl/csel_line_drv.sv
module csel_line_drv
  import spi_csel_pkg::*;
#(
  parameter int   IDX_W     = 2,
  parameter int   LINE      = 0,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] target_idx,
  input  logic             manual,
  input  logic             lvl,
  input  logic             busy,
  input  logic             act_low,
  output logic             cs
);

  logic hit;
  assign hit = (target_idx == IDX_W'(LINE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs <= RST_LEVEL;
    else        cs <= line_next(hit, manual, lvl, busy, act_low);
  end

endmodule

// File: rtl/spi_csel_ctrl.sv
module spi_csel_ctrl #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     sel_idx,
  input  logic                 manual_en,
  input  logic                 manual_lvl,
  input  logic                 act_low,
  input  logic                 burst_busy,
  output logic [NUM_LINES-1:0] cs_o
);

  localparam logic RST_LEVEL = 1'b1;   // active-low polarity out of reset

  logic [IDX_W-1:0] eff_idx;
  logic [IDX_W-1:0] lock_idx;
  logic [IDX_W-1:0] target_idx;
  logic             burst_q;
  logic             burst_start;

  csel_index_lock #(.IDX_W(IDX_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_idx     (sel_idx),
    .burst_busy  (burst_busy),
    .eff_idx     (eff_idx),
    .lock_idx    (lock_idx),
    .burst_q     (burst_q),
    .burst_start (burst_start)
  );

  // Manual mode follows the live index; automatic mode uses the locked one.
  assign target_idx = manual_en ? sel_idx : eff_idx;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    csel_line_drv #(
      .IDX_W     (IDX_W),
      .LINE      (g),
      .RST_LEVEL (RST_LEVEL)
    ) u_drv (
      .clk        (clk),
      .rst_n      (rst_n),
      .target_idx (target_idx),
      .manual     (manual_en),
      .lvl        (manual_lvl),
      .busy       (burst_busy),
      .act_low    (act_low),
      .cs         (cs_o[g])
    );
  end

endmodule

// File: rtl/spi_csel_ctrl_chk.sv
module spi_csel_ctrl_chk #(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [IDX_W-1:0]     sel_idx,
  input logic                 manual_en,
  input logic                 manual_lvl,
  input logic                 act_low,
  input logic                 burst_busy,
  input logic [NUM_LINES-1:0] cs_o,
  input logic [IDX_W-1:0]     eff_idx,
  input logic [IDX_W-1:0]     lock_idx,
  input logic                 burst_q,
  input logic                 burst_start
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8: lines held high throughout reset
  always @(negedge clk) begin
    if (!rst_n) p_reset_high_r8: assert (cs_o == '1);
  end

  // R1, R4: no more than one line away from the resting level
  p_one_active_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $countones(cs_o ^ {NUM_LINES{$past(act_low)}}) <= 1);

  // R3: manual target line follows the level bit
  p_manual_level_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(manual_en) |-> cs_o[$past(sel_idx)] == $past(manual_lvl));

  // R5: automatic burst drives the locked line active
  p_auto_active_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(!manual_en) && $past(burst_busy)) |->
      cs_o[$past(eff_idx)] == ~$past(act_low));

  // R6: automatic idle leaves every line at rest
  p_auto_idle_r6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(!manual_en) && $past(!burst_busy)) |->
      cs_o == {NUM_LINES{$past(act_low)}});

  // R7: the locked index captures at burst start and holds while busy
  p_lock_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> lock_idx == $past(sel_idx));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_q && burst_busy) |=> $stable(lock_idx));

endmodule

bind spi_csel_ctrl spi_csel_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_idx     (sel_idx),
  .manual_en   (manual_en),
  .manual_lvl  (manual_lvl),
  .act_low     (act_low),
  .burst_busy  (burst_busy),
  .cs_o        (cs_o),
  .eff_idx     (eff_idx),
  .lock_idx    (lock_idx),
  .burst_q     (burst_q),
  .burst_start (burst_start)
);

// File: tb/spi_csel_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_csel_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_idx = 2'd0;
  logic       manual_en = 1'b0;
  logic       manual_lvl = 1'b0;
  logic       act_low = 1'b1;
  logic       burst_busy = 1'b0;
  logic [3:0] cs_o;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  logic [3:0] want = 4'hF;
  bit         in_burst = 1'b0;
  int         frozen = 0;

  always #5 clk = ~clk;

  spi_csel_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_idx    (sel_idx),
    .manual_en  (manual_en),
    .manual_lvl (manual_lvl),
    .act_low    (act_low),
    .burst_busy (burst_busy),
    .cs_o       (cs_o)
  );

  // One clock: update the model from the inputs sampled at the rising edge,
  // then compare at the falling edge.
  task automatic tick(input string tag);
    int pick;
    @(posedge clk);
    if (!rst_n) begin
      want = 4'hF;
      in_burst = 1'b0;
      frozen = 0;
    end else begin
      pick = in_burst ? frozen : int'(sel_idx);
      want = act_low ? 4'hF : 4'h0;
      if (manual_en)       want[sel_idx] = manual_lvl;
      else if (burst_busy) want[pick] = ~act_low;
      if (!in_burst) frozen = int'(sel_idx);
      in_burst = burst_busy;
    end
    @(negedge clk);
    vectors++;
    if (cs_o !== want) begin
      miscompares++;
      $display("FAIL %s: cs_o=%b expected %b at %0t", tag, cs_o, want, $time);
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    // R8: reset holds every line high
    run(3, "R8");
    rst_n = 1'b1;

    // R6: automatic idle, active-low
    run(3, "R6");

    // R5: one burst on each index
    for (int i = 0; i < 4; i++) begin
      sel_idx = 2'(i);
      burst_busy = 1'b1;
      run(3, "R5");
      burst_busy = 1'b0;
      run(2, "R6");
    end

    // R7: retarget in the middle of a burst, then a fresh burst
    sel_idx = 2'd1;
    burst_busy = 1'b1;
    run(2, "R7");
    sel_idx = 2'd3;
    run(3, "R7");
    burst_busy = 1'b0;
    run(1, "R7");
    burst_busy = 1'b1;
    run(3, "R7");
    burst_busy = 1'b0;
    run(2, "R7");

    // R3: manual levels on every index
    manual_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sel_idx = 2'(i);
      manual_lvl = 1'b0;
      run(1, "R3");
      manual_lvl = 1'b1;
      run(1, "R3");
    end
    // R3: manual mode ignores burst_busy
    burst_busy = 1'b1;
    run(2, "R3");
    burst_busy = 1'b0;

    // R4: active-high polarity in both modes
    act_low = 1'b0;
    sel_idx = 2'd2;
    manual_lvl = 1'b1;
    run(2, "R4");
    manual_en = 1'b0;
    run(2, "R4");
    burst_busy = 1'b1;
    run(3, "R4");
    burst_busy = 1'b0;
    run(2, "R4");

    // R2: inputs toggling every cycle, each seen one edge later
    for (int k = 0; k < 8; k++) begin
      act_low = ~act_low;
      burst_busy = k[0];
      sel_idx = 2'(k);
      tick("R2");
    end

    // R1: pseudo-random stimulus on all inputs
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel_idx = lf[1:0];
      manual_en = (lf[5:3] == 3'd0);
      manual_lvl = lf[6];
      if (lf[11:8] == 4'd0) act_low = ~act_low;
      burst_busy = lf[7] | lf[2];
      tick("R1");
    end

    // R8: reset again mid-run
    rst_n = 1'b0;
    run(2, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule